// File: doc/BRIEF.md
# Boot-Mirroring PRG Bank Mapper

This block is the address logic on the cartridge side of the program (PRG) bus. It watches the console CPU's bus strobe (Phi2), read/write line, active-low PRG select, the fifteen low address lines and the low data lines. From these it drives the chip enables and address lines for two memories: a small boot memory and a large game memory.

After reset the block is in boot mode. In this mode every PRG access is folded onto the 8 KB boot memory, whatever the upper address lines carry, so the CPU finds its reset vector at once.

When the loader controller raises the mode input, the block switches to game mode. It then behaves as a simple switchable-plus-fixed bank mapper. A CPU write to PRG space stores a bank number in a latch. The lower 16 KB window follows that latch. The upper 16 KB window is pinned to the last bank, because A14 is ORed into every bank bit.

The block runs on a fast local clock and oversamples the CPU bus. A write is committed when Phi2 is seen falling. The mode input is taken only while Phi2 is low. The enables and addresses are combinational from the live address and registered state, so they fit well inside the read decode window.

Top module: `prg_boot_mapper`

## Requirements
- R1: After reset the bank latch holds 0 and the block is in boot mode, so a PRG access (`prg_sel_n` low) drives `boot_ce_n` low and `game_ce_n` high.
- R2: In boot mode, `boot_addr` equals the low 13 address bits for any PRG address (A14 and A13 have no effect), `game_ce_n` stays high, `game_addr` bits 17:14 read 0, and `boot_ce_n` is low only while `prg_sel_n` is low.
- R3: The reset vector reads at $FFFC and $FFFD select the boot memory at offsets 0x1FFC and 0x1FFD from the first cycle after reset.
- R4: In game mode, `game_ce_n` is low exactly when `prg_sel_n` is low, and `boot_ce_n` stays high; the two enables are never low together.
- R5: In game mode, a CPU cycle with `cpu_rw` low and `prg_sel_n` low loads `cpu_data_lo` into the 4-bit bank latch when Phi2 falls. Bank values 0 through 15 are all reachable.
- R6: In game mode with A14 (`cpu_addr[14]`) high, `game_addr[17:14]` is 0xF whatever the latch holds.
- R7: In game mode with A14 low, `game_addr[17:14]` equals the latch, and `game_addr[13:0]` always equals `cpu_addr[13:0]`.
- R8: Writes made while in boot mode leave the latch unchanged; this is seen through `game_addr` once game mode is entered.
- R9: The latch takes the data present while Phi2 was high. Data that changes after Phi2 falls is ignored.
- R10: A change on `game_mode` while Phi2 is high has no effect on the enables until Phi2 goes low.
- R11: Read cycles and write cycles with `prg_sel_n` high leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU bus phase strobe |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| prg_sel_n | input | 1 | Active-low PRG space select ($8000-$FFFF) |
| cpu_addr | input | 15 | CPU address A14..A0 |
| cpu_data_lo | input | 4 | CPU data D3..D0, the only data lines wired to the latch |
| game_mode | input | 1 | Loader mode request: 0 boot, 1 game |
| boot_ce_n | output | 1 | Active-low boot memory enable |
| boot_addr | output | 13 | Boot memory address |
| game_ce_n | output | 1 | Active-low game memory enable |
| game_addr | output | 18 | Game memory address: bank in 17:14, offset in 13:0 |

## Verification
The bench builds the block with its default parameters: a 4-bit latch, a 15-bit CPU address and a 13-bit boot window. With these values all sixteen banks are reachable, including the boundary values 0 and 15, and the fixed upper window reads as bank 15. Each CPU cycle is only a few local clocks long, so many bus cycles fit in a short run. Junk data is driven in every Phi2-low phase, and this exercises the capture-on-fall rule on every write.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  typedef enum logic {
    MAP_BOOT = 1'b0,
    MAP_GAME = 1'b1
  } map_mode_e;

  localparam int MAX_BANK_W = 8;

  // Upper window folding: the high address line forces every bank bit to one.
  function automatic logic [MAX_BANK_W-1:0] fold_window(
    input logic [MAX_BANK_W-1:0] latch_val,
    input logic                  hi_line
  );
    return latch_val | {MAX_BANK_W{hi_line}};
  endfunction

endpackage

// File: rtl/prg_bus_sampler.sv
module prg_bus_sampler #(
  parameter int CAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2,
  input  logic             cpu_rw,
  input  logic             prg_sel_n,
  input  logic [CAP_W-1:0] cpu_data,
  output logic             rw_s,
  output logic             sel_n_s,
  output logic [CAP_W-1:0] data_s,
  output logic             fall_evt
);

  logic phi2_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_s  <= 1'b0;
      rw_s    <= 1'b1;
      sel_n_s <= 1'b1;
      data_s  <= '0;
    end else begin
      phi2_s  <= phi2;
      rw_s    <= cpu_rw;
      sel_n_s <= prg_sel_n;
      data_s  <= cpu_data;
    end
  end

  // Phi2 was high at the previous sample and is low now.
  assign fall_evt = phi2_s & ~phi2;

endmodule

// File: rtl/prg_mode_sync.sv
module prg_mode_sync
  import prg_map_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      phi2,
  input  logic      game_mode,
  output map_mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MAP_BOOT;
    end else if (!phi2) begin
      mode_q <= game_mode ? MAP_GAME : MAP_BOOT;
    end
  end

endmodule

// File: rtl/prg_bank_latch.sv
module prg_bank_latch
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic              rw_s,
  input  logic              sel_n_s,
  input  logic [BANK_W-1:0] data_s,
  input  map_mode_e         mode_q,
  output logic              wr_evt,
  output logic [BANK_W-1:0] bank_q
);

  assign wr_evt = fall_evt & ~rw_s & ~sel_n_s & (mode_q == MAP_GAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_evt) begin
      bank_q <= data_s;
    end
  end

endmodule

// File: rtl/prg_decode.sv
module prg_decode
  import prg_map_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int ADDR_W  = 15,
  parameter int BOOT_AW = 13,
  localparam int OFS_W  = ADDR_W - 1,
  localparam int GA_W   = BANK_W + OFS_W
) (
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               prg_sel_n,
  input  map_mode_e          mode_q,
  input  logic [BANK_W-1:0]  bank_q,
  output logic               boot_ce_n,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic               game_ce_n,
  output logic [GA_W-1:0]    game_addr
);

  logic                  hi_line;
  logic                  in_game;
  logic [MAX_BANK_W-1:0] folded;
  logic [BANK_W-1:0]     bank_out;

  assign hi_line = cpu_addr[ADDR_W-1];
  assign in_game = (mode_q == MAP_GAME);
  assign folded  = fold_window(MAX_BANK_W'(bank_q), hi_line);

  for (genvar i = 0; i < BANK_W; i++) begin : g_bank_bit
    assign bank_out[i] = in_game & folded[i];
  end

  assign boot_ce_n = ~(~prg_sel_n & ~in_game);
  assign game_ce_n = ~(~prg_sel_n &  in_game);
  assign boot_addr = cpu_addr[BOOT_AW-1:0];
  assign game_addr = {bank_out, cpu_addr[OFS_W-1:0]};

endmodule

// File: rtl/prg_boot_mapper.sv
module prg_boot_mapper
  import prg_map_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int ADDR_W  = 15,
  parameter int BOOT_AW = 13,
  localparam int GA_W   = BANK_W + ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phi2,
  input  logic               cpu_rw,
  input  logic               prg_sel_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [BANK_W-1:0]  cpu_data_lo,
  input  logic               game_mode,
  output logic               boot_ce_n,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic               game_ce_n,
  output logic [GA_W-1:0]    game_addr
);

  logic              rw_s;
  logic              sel_n_s;
  logic [BANK_W-1:0] data_s;
  logic              fall_evt;
  logic              wr_evt;
  logic [BANK_W-1:0] bank_q;
  map_mode_e         mode_q;

  prg_bus_sampler #(.CAP_W(BANK_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .cpu_rw   (cpu_rw),
    .prg_sel_n(prg_sel_n),
    .cpu_data (cpu_data_lo),
    .rw_s     (rw_s),
    .sel_n_s  (sel_n_s),
    .data_s   (data_s),
    .fall_evt (fall_evt)
  );

  prg_mode_sync u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .phi2     (phi2),
    .game_mode(game_mode),
    .mode_q   (mode_q)
  );

  prg_bank_latch #(.BANK_W(BANK_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_evt(fall_evt),
    .rw_s    (rw_s),
    .sel_n_s (sel_n_s),
    .data_s  (data_s),
    .mode_q  (mode_q),
    .wr_evt  (wr_evt),
    .bank_q  (bank_q)
  );

  prg_decode #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .BOOT_AW(BOOT_AW)
  ) u_decode (
    .cpu_addr (cpu_addr),
    .prg_sel_n(prg_sel_n),
    .mode_q   (mode_q),
    .bank_q   (bank_q),
    .boot_ce_n(boot_ce_n),
    .boot_addr(boot_addr),
    .game_ce_n(game_ce_n),
    .game_addr(game_addr)
  );

endmodule

// File: rtl/prg_boot_mapper_chk.sv
module prg_boot_mapper_chk #(
  parameter int BANK_W = 4,
  parameter int GA_W   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              hi_line,
  input logic              prg_sel_n,
  input logic              boot_ce_n,
  input logic              game_ce_n,
  input logic [GA_W-1:0]   game_addr,
  input logic              mode_game,
  input logic              wr_evt,
  input logic [BANK_W-1:0] data_s,
  input logic [BANK_W-1:0] bank_q
);

  // R4
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!boot_ce_n && !game_ce_n));

  // R2
  boot_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_game && !prg_sel_n) |-> (!boot_ce_n && game_ce_n));

  // R6
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_game && hi_line) |-> (game_addr[GA_W-1 -: BANK_W] == {BANK_W{1'b1}}));

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (bank_q == $past(data_s)));

  // R8
  boot_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_game |=> $stable(bank_q));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(bank_q));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phi2 |=> $stable(mode_game));

endmodule

bind prg_boot_mapper prg_boot_mapper_chk #(
  .BANK_W(BANK_W),
  .GA_W  (GA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phi2     (phi2),
  .hi_line  (cpu_addr[ADDR_W-1]),
  .prg_sel_n(prg_sel_n),
  .boot_ce_n(boot_ce_n),
  .game_ce_n(game_ce_n),
  .game_addr(game_addr),
  .mode_game(mode_q == prg_map_pkg::MAP_GAME),
  .wr_evt   (wr_evt),
  .data_s   (data_s),
  .bank_q   (bank_q)
);

// File: tb/prg_boot_mapper_tb.sv
module prg_boot_mapper_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic        cpu_rw = 1'b1;
  logic        prg_sel_n = 1'b1;
  logic [14:0] cpu_addr = '0;
  logic [3:0]  cpu_data_lo = '0;
  logic        game_mode = 1'b0;
  logic        boot_ce_n;
  logic [12:0] boot_addr;
  logic        game_ce_n;
  logic [17:0] game_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  int m_bank = 0;
  int m_game = 0;
  int m_prev_phi2 = 0;
  int m_rw = 1;
  int m_sel_n = 1;
  int m_data = 0;

  always #10 clk = ~clk;

  prg_boot_mapper u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .phi2       (phi2),
    .cpu_rw     (cpu_rw),
    .prg_sel_n  (prg_sel_n),
    .cpu_addr   (cpu_addr),
    .cpu_data_lo(cpu_data_lo),
    .game_mode  (game_mode),
    .boot_ce_n  (boot_ce_n),
    .boot_addr  (boot_addr),
    .game_ce_n  (game_ce_n),
    .game_addr  (game_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Reference model, advanced on every rising clock edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_game = 0; m_prev_phi2 = 0; m_rw = 1; m_sel_n = 1; m_data = 0;
    end else begin
      if (m_prev_phi2 == 1 && phi2 == 0 && m_rw == 0 && m_sel_n == 0 && m_game == 1)
        m_bank = m_data;
      if (phi2 == 0) m_game = game_mode ? 1 : 0;
      m_prev_phi2 = phi2;
      m_rw = cpu_rw;
      m_sel_n = prg_sel_n;
      m_data = int'(cpu_data_lo);
    end
  end

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_bank;
      int sel;
      sel = (prg_sel_n == 0) ? 1 : 0;
      if (m_game == 0) exp_bank = 0;
      else if (cpu_addr[14]) exp_bank = 15;
      else exp_bank = m_bank;
      chk("R2 R4 boot enable", int'(boot_ce_n), (sel == 1 && m_game == 0) ? 0 : 1);
      chk("R2 R4 game enable", int'(game_ce_n), (sel == 1 && m_game == 1) ? 0 : 1);
      chk("R6 R7 bank lines", int'(game_addr[17:14]), exp_bank);
      chk("R7 offset lines", int'(game_addr[13:0]), int'(cpu_addr) % 16384);
      chk("R2 boot offset", int'(boot_addr), int'(cpu_addr) % 8192);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_sim();
    end
  end

  // One CPU bus cycle: Phi2 low with junk data, then high with real data.
  task automatic cpu_access(input logic [15:0] a, input logic [3:0] d, input logic rw);
    @(posedge clk); #5;
    phi2 = 0; cpu_addr = a[14:0]; prg_sel_n = ~a[15]; cpu_rw = rw;
    cpu_data_lo = d ^ 4'hA;
    repeat (3) @(posedge clk);
    #5;
    phi2 = 1; cpu_data_lo = d;
    repeat (3) @(posedge clk);
  endtask

  // Ends any pending cycle and parks on a read at address a with Phi2 low.
  task automatic observe(input logic [15:0] a);
    @(posedge clk); #5;
    phi2 = 0; cpu_addr = a[14:0]; prg_sel_n = ~a[15]; cpu_rw = 1;
    cpu_data_lo = 4'h6;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic enter_game();
    @(posedge clk); #5;
    phi2 = 0; game_mode = 1;
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;

    // R1, R3: reset vector fetch straight out of reset
    cpu_addr = 15'h7FFC; prg_sel_n = 0; cpu_rw = 1;
    @(negedge clk);
    chk("R1 boot enable after reset", int'(boot_ce_n), 0);
    chk("R1 game enable after reset", int'(game_ce_n), 1);
    chk("R3 vector low byte", int'(boot_addr), 'h1FFC);
    @(posedge clk); #5 cpu_addr = 15'h7FFD;
    @(negedge clk);
    chk("R3 vector high byte", int'(boot_addr), 'h1FFD);

    // R2: mirroring ignores A14 and A13
    observe(16'hA123);
    chk("R2 mirror low window", int'(boot_addr), 'h0123);
    observe(16'hE123);
    chk("R2 mirror high window", int'(boot_addr), 'h0123);
    chk("R2 game idle in boot", int'(game_ce_n), 1);
    observe(16'h6123);
    chk("R2 no enable without select", int'(boot_ce_n), 1);

    // R8: boot-mode write must not load the latch
    cpu_access(16'h8000, 4'h7, 0);
    observe(16'h8000);

    // R10: mode raised during Phi2 high is held off
    @(posedge clk); #5 phi2 = 1; game_mode = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 still boot while Phi2 high", int'(boot_ce_n), 0);
    chk("R10 game held off", int'(game_ce_n), 1);
    enter_game();
    observe(16'h8000);
    chk("R10 game after Phi2 low", int'(game_ce_n), 0);
    chk("R4 boot idle in game", int'(boot_ce_n), 1);
    chk("R8 latch untouched by boot write", int'(game_addr[17:14]), 0);

    // R5, R7: loads including boundaries
    cpu_access(16'h8000, 4'h5, 0);
    observe(16'h8ABC);
    chk("R5 load 5", int'(game_addr[17:14]), 5);
    chk("R7 offset", int'(game_addr[13:0]), 'h0ABC);
    observe(16'hC000);
    chk("R6 upper window fixed", int'(game_addr[17:14]), 15);
    cpu_access(16'hFFFF, 4'hF, 0);
    observe(16'h8000);
    chk("R5 load 15", int'(game_addr[17:14]), 15);
    cpu_access(16'hC123, 4'h0, 0);
    observe(16'h8000);
    chk("R5 load 0", int'(game_addr[17:14]), 0);
    observe(16'hF000);
    chk("R6 fixed with latch 0", int'(game_addr[17:14]), 15);

    // R9: junk data after the fall (cpu_access drives d^A in low phase)
    cpu_access(16'h9000, 4'h3, 0);
    observe(16'h8000);
    chk("R9 captured high-phase data", int'(game_addr[17:14]), 3);

    // R11: reads and unselected writes leave the latch
    cpu_access(16'h8000, 4'h9, 1);
    observe(16'h8000);
    chk("R11 read ignored", int'(game_addr[17:14]), 3);
    cpu_access(16'h6000, 4'hC, 0);
    observe(16'h8000);
    chk("R11 unselected write ignored", int'(game_addr[17:14]), 3);
    observe(16'h6000);
    chk("R4 no enable without select", int'(game_ce_n), 1);

    // sweep all banks
    for (int b = 0; b < 16; b++) begin
      cpu_access(16'h8000 + 16'(b), 4'(b), 0);
      observe(16'h8000);
      chk("R5 sweep", int'(game_addr[17:14]), b);
    end

    repeat (4) @(posedge clk);
    finish_sim();
  end

endmodule